// File: doc/BRIEF.md
# Streaming 3x3 Convolution Filter

This block filters an image that arrives one pixel at a time, in raster order, over a valid/ready stream. Each output pixel is the weighted sum of the 3x3 neighbourhood around the matching input pixel. Nine signed fixed-point weights set the sum and are loaded through a simple write port. Neighbours that fall outside the frame take the value of the nearest edge pixel. The filter therefore never reads past the image and never pads with zeros.

Two earlier image lines are held in two separate line memories, so both can be read in the same cycle. A 3x3 register window shifts by one column per step, which sustains one pixel per clock. Results come out one row and one column behind the input. After the last input pixel the block keeps stepping on an internal zero pixel until the final row and column are produced. A start-of-frame pulse captures the frame size and restarts the counters. When the output is not accepted, the whole pipeline stalls.

Top module: `conv3_stream_filter`

## Requirements
- R1: A frame of width W and height H gives exactly W*H results in raster order. `out_last_o` is high with the final result only.
- R2: The result for (x, y) is the sum over r, c in {0,1,2} of p(clamp(x+c-1), clamp(y+r-1)) times weight[3r+c]. The clamp limits a column to 0..W-1 and a row to 0..H-1.
- R3: Pixels are signed 16-bit and weights are signed Q1.14. The output is floor((S + 8192) / 16384) for the exact sum S, saturated to the range -32768..32767.
- R4: With input valid and output ready held high, the first result is registered at the (W+2)th clock edge after the edge that samples `sof_i`. The last result is registered at edge W*(H+1)+1, and results are valid on every cycle in between.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_last_o` hold, `in_ready_o` is low, and no data is lost.
- R6: Once W*H pixels of a frame have been accepted, `in_ready_o` stays low while the block drains on its own.
- R7: Width and height are sampled only at `sof_i`. Changing `width_i` or `height_i` during a frame has no effect on that frame.
- R8: Weight index k = 3r + c, where r = 0 is the row above, r = 2 is the row below, c = 0 is the left column and c = 2 is the right column. A weight is written at a clock edge where `coef_we_i` is high.
- R9: After reset, including a reset in mid-frame, `in_ready_o`, `out_valid_o` and `out_last_o` are low until the next `sof_i`.
- R10: Before the first `sof_i` and after a frame ends, `in_ready_o` is low and input pixels produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse; samples the frame size |
| width_i | input | DIM_W | Frame width in pixels, 1..MAX_W |
| height_i | input | DIM_W | Frame height in lines, at least 1 |
| coef_we_i | input | 1 | Weight write enable |
| coef_idx_i | input | 4 | Weight index, 3*row + column |
| coef_i | input | COEF_W | Weight value, signed Q1.14 |
| in_valid_i | input | 1 | Input pixel valid |
| in_data_i | input | PIX_W | Input pixel, signed |
| in_ready_o | output | 1 | Input pixel accepted when high together with valid |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | PIX_W | Filtered pixel, signed |
| out_last_o | output | 1 | Marks the final result of the frame |
| out_ready_i | input | 1 | Downstream accepts the result |

## Verification
The assertions check the stream rules on every cycle:
- the result holds still under backpressure, and input is refused at the same time;
- `out_last_o` appears on exactly the W*H-th accepted result;
- no pixel is accepted past W*H, and input stays closed after the frame ends.

Only the bench scenarios can show the rest:
- the arithmetic is correct, including edge replication at every corner, weight orientation, rounding of halves and saturation;
- the cycle count with a free-flowing stream;
- single-row, single-column and full-width frames;
- a mid-frame size change and a reset in the middle of a frame.

// File: rtl/conv3_pkg.sv
`timescale 1ns/1ps
package conv3_pkg;
  localparam int KDIM  = 3;
  localparam int KTAPS = KDIM * KDIM;
  localparam int CIDX_W = $clog2(KTAPS);
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/conv3_line_store.sv
`timescale 1ns/1ps
module conv3_line_store #(
  parameter int PIX_W  = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   wr_en_i,
  input  logic                   bank_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [PIX_W-1:0]       wr_data_i,
  output logic [1:0][PIX_W-1:0]  rd_data_o
);
  // one memory per stored line so both are read in the same cycle
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (bank_i == 1'(b))) mem[addr_i] <= wr_data_i;
    end
    assign rd_data_o[b] = mem[addr_i];
  end
endmodule

// File: rtl/conv3_window.sv
`timescale 1ns/1ps
module conv3_window import conv3_pkg::*; #(
  parameter int PIX_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic [KDIM-1:0][PIX_W-1:0]  col_i,
  input  logic                        left_i,
  input  logic                        right_i,
  input  logic                        top_i,
  input  logic                        bot_i,
  output logic [KTAPS-1:0][PIX_W-1:0] taps_o
);
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0] win_q, win_n;

  always_comb begin
    for (int r = 0; r < KDIM; r++) begin
      for (int c = 0; c < KDIM-1; c++) win_n[r][c] = win_q[r][c+1];
      win_n[r][KDIM-1] = col_i[r];
    end
  end

  // edge replication: out-of-frame taps fold back onto the centre row/column
  always_comb begin
    for (int r = 0; r < KDIM; r++) begin
      for (int c = 0; c < KDIM; c++) begin
        int rs, cs;
        rs = ((r == 0 && top_i) || (r == KDIM-1 && bot_i))   ? 1 : r;
        cs = ((c == 0 && left_i) || (c == KDIM-1 && right_i)) ? 1 : c;
        taps_o[r*KDIM + c] = win_n[rs][cs];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (adv_i) win_q <= win_n;
  end
endmodule

// File: rtl/conv3_mac.sv
`timescale 1ns/1ps
module conv3_mac import conv3_pkg::*; #(
  parameter int PIX_W  = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36,
  parameter int FRAC   = 14
) (
  input  logic [KTAPS-1:0][PIX_W-1:0]  taps_i,
  input  logic [KTAPS-1:0][COEF_W-1:0] coef_i,
  output logic [PIX_W-1:0]             res_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (PIX_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(64'sd1 <<< (FRAC-1));

  logic signed [ACC_W-1:0] acc, scaled;

  always_comb begin
    acc = '0;
    for (int k = 0; k < KTAPS; k++) begin
      logic signed [PIX_W-1:0]  p;
      logic signed [COEF_W-1:0] w;
      logic signed [ACC_W-1:0]  pe, we;
      p   = taps_i[k];
      w   = coef_i[k];
      pe  = ACC_W'(p);
      we  = ACC_W'(w);
      acc = acc + pe * we;
    end
    scaled = (acc + HALF) >>> FRAC;
    if (scaled > SAT_HI)      res_o = SAT_HI[PIX_W-1:0];
    else if (scaled < SAT_LO) res_o = SAT_LO[PIX_W-1:0];
    else                      res_o = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/conv3_stream_filter.sv
`timescale 1ns/1ps
module conv3_stream_filter import conv3_pkg::*; #(
  parameter int PIX_W  = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36,
  parameter int FRAC   = 14,
  parameter int MAX_W  = 64,
  parameter int DIM_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              coef_we_i,
  input  logic [CIDX_W-1:0] coef_idx_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              in_valid_i,
  input  logic [PIX_W-1:0]  in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam int ADDR_W = $clog2(MAX_W);

  run_state_e                    run_q;
  logic [DIM_W-1:0]              w_q, h_q, w_m1, h_m1, ix_q;
  logic [DIM_W:0]                iy_q;
  logic signed [DIM_W:0]         ox_q, oy_q;
  logic [KTAPS-1:0][COEF_W-1:0]  coef_q;
  logic                          rows_left, out_free, adv, emit, last;
  logic                          at_left, at_right, at_top, at_bot;
  logic [PIX_W-1:0]              cur, res;
  logic [1:0][PIX_W-1:0]         lb_rd;
  logic [KDIM-1:0][PIX_W-1:0]    col;
  logic [KTAPS-1:0][PIX_W-1:0]   taps;

  assign w_m1      = w_q - DIM_W'(1);
  assign h_m1      = h_q - DIM_W'(1);
  assign rows_left = iy_q < {1'b0, h_q};
  assign out_free  = !out_valid_o || out_ready_i;
  assign adv       = (run_q == ST_RUN) && out_free && (!rows_left || in_valid_i);
  assign in_ready_o = (run_q == ST_RUN) && out_free && rows_left;
  assign cur       = rows_left ? in_data_i : '0;   // drain steps feed zero

  assign emit     = !ox_q[DIM_W] && !oy_q[DIM_W];
  assign at_left  = (ox_q == '0);
  assign at_top   = (oy_q == '0);
  assign at_right = !ox_q[DIM_W] && (ox_q[DIM_W-1:0] == w_m1);
  assign at_bot   = !oy_q[DIM_W] && (oy_q[DIM_W-1:0] == h_m1);
  assign last     = emit && at_right && at_bot;

  // bank iy%2 holds row iy-2, the other bank row iy-1
  assign col[0] = lb_rd[iy_q[0]];
  assign col[1] = lb_rd[~iy_q[0]];
  assign col[2] = cur;

  conv3_line_store #(.PIX_W(PIX_W), .DEPTH(MAX_W)) u_lines (
    .clk_i     (clk_i),
    .wr_en_i   (adv),
    .bank_i    (iy_q[0]),
    .addr_i    (ix_q[ADDR_W-1:0]),
    .wr_data_i (cur),
    .rd_data_o (lb_rd)
  );

  conv3_window #(.PIX_W(PIX_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .col_i   (col),
    .left_i  (at_left),
    .right_i (at_right),
    .top_i   (at_top),
    .bot_i   (at_bot),
    .taps_o  (taps)
  );

  conv3_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
    .taps_i (taps),
    .coef_i (coef_q),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= '0;
    else if (coef_we_i && (coef_idx_i < CIDX_W'(KTAPS))) coef_q[coef_idx_i] <= coef_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= ST_IDLE;
      w_q   <= '0;
      h_q   <= '0;
      ix_q  <= '0;
      iy_q  <= '0;
      ox_q  <= '1;
      oy_q  <= '1;
    end else if (sof_i) begin
      run_q <= ST_RUN;
      w_q   <= width_i;
      h_q   <= height_i;
      ix_q  <= '0;
      iy_q  <= '0;
      ox_q  <= '1;
      oy_q  <= '1;
    end else if (adv) begin
      if (ix_q == w_m1) begin
        ix_q <= '0;
        iy_q <= iy_q + (DIM_W+1)'(1);
      end else begin
        ix_q <= ix_q + DIM_W'(1);
      end
      if (at_right) begin
        ox_q <= '0;
        oy_q <= oy_q + (DIM_W+1)'(1);
      end else begin
        ox_q <= ox_q + (DIM_W+1)'(1);
      end
      if (last) run_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_data_o  <= '0;
    end else if (sof_i) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (adv) begin
      out_valid_o <= emit;
      out_last_o  <= last;
      out_data_o  <= res;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/conv3_checks.sv
`timescale 1ns/1ps
module conv3_checks #(
  parameter int PIX_W = 16,
  parameter int DIM_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic [DIM_W-1:0] width_i,
  input logic [DIM_W-1:0] height_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [PIX_W-1:0] out_data_o,
  input logic             out_last_o,
  input logic             out_ready_i
);
  logic [DIM_W-1:0]   w_l, h_l;
  logic [2*DIM_W-1:0] in_cnt, out_cnt, total;

  assign total = (2*DIM_W)'(w_l) * (2*DIM_W)'(h_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_l <= '0; h_l <= '0; in_cnt <= '0; out_cnt <= '0;
    end else if (sof_i) begin
      w_l <= width_i; h_l <= height_i; in_cnt <= '0; out_cnt <= '0;
    end else begin
      if (in_valid_i && in_ready_o)   in_cnt  <= in_cnt + 1'b1;
      if (out_valid_o && out_ready_i) out_cnt <= out_cnt + 1'b1;
    end
  end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !sof_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  assert_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_last_pos_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |-> (out_last_o == (out_cnt == total - 1'b1)));

  assert_no_extra_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cnt == total && !sof_i) |-> !in_ready_o);

  assert_idle_after_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o && !sof_i) |=> !in_ready_o);
endmodule

bind conv3_stream_filter conv3_checks #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .width_i     (width_i),
  .height_i    (height_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/sim_conv3_stream_filter.sv
`timescale 1ns/1ps
module sim_conv3_stream_filter;
  localparam int PIX_W = 16;
  localparam int DIM_W = 12;
  localparam int NCASE = 8;
  // columns: width, height, kernel set, pixel pattern, ready mode, valid mode, resize mid-frame
  localparam int CASES [NCASE][7] = '{
    '{ 5, 4, 0, 0, 0, 0, 0},
    '{ 6, 5, 1, 1, 1, 0, 1},
    '{ 1, 1, 2, 0, 0, 2, 0},
    '{ 7, 1, 1, 1, 2, 2, 0},
    '{ 1, 6, 1, 1, 0, 1, 0},
    '{64, 3, 2, 1, 2, 2, 0},
    '{ 4, 4, 3, 2, 0, 0, 0},
    '{ 8, 3, 4, 3, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sof_i = 1'b0;
  logic [DIM_W-1:0] width_i = '0, height_i = '0;
  logic coef_we_i = 1'b0;
  logic [3:0] coef_idx_i = '0;
  logic [15:0] coef_i = '0;
  logic in_valid_i = 1'b0;
  logic [PIX_W-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_last_o;
  logic [PIX_W-1:0] out_data_o;
  logic out_ready_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int img [256];
  int expv[256];

  always #5 clk = ~clk;

  conv3_stream_filter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof_i), .width_i(width_i), .height_i(height_i),
    .coef_we_i(coef_we_i), .coef_idx_i(coef_idx_i), .coef_i(coef_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .out_ready_i(out_ready_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kcoef(int ks, int k);
    case (ks)
      0: return (k == 4) ? 16384 : 0;
      1: return k * 1000 - 3000;
      2: return 1820;
      3: return 32767;
      default: return (k == 4) ? 8192 : 0;
    endcase
  endfunction

  function automatic int pixv(int pat, int x, int y);
    case (pat)
      0: return x * 150 + y * 900 - 2000;
      1: return (((x * 37 + y * 91 + x * y * 13) % 4001) - 2000) * 8;
      2: return ((x + y) % 2) ? -32768 : 32767;
      default: return ((x * 3 + y * 5) % 21) - 10;
    endcase
  endfunction

  function automatic int clampi(int v, int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic build_expect(int w, int h, int ks, int pat);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) img[y*w + x] = pixv(pat, x, y);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        longint s = 0;
        longint r;
        for (int rr = 0; rr < 3; rr++)
          for (int cc = 0; cc < 3; cc++)
            s += longint'(pixv(pat, clampi(x+cc-1, w-1), clampi(y+rr-1, h-1))) * kcoef(ks, rr*3+cc);
        r = (s + 64'sd8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        expv[y*w + x] = int'(r);
      end
  endtask

  task automatic load_kernel(int ks);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      coef_we_i = 1'b1; coef_idx_i = 4'(k); coef_i = 16'(kcoef(ks, k));
    end
    @(negedge clk);
    coef_we_i = 1'b0;
  endtask

  function automatic bit mode_on(int mode, int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      default: return $urandom_range(0, 3) != 0;
    endcase
  endfunction

  task automatic run_frame(int ci);
    int w, h, ks, pat, rdy, vld, chg, npix, pidx, oidx, cyc, first_out, last_out;
    bit done, held, drain_bad;
    logic [PIX_W-1:0] held_data;
    string tag;
    w = CASES[ci][0]; h = CASES[ci][1]; ks = CASES[ci][2]; pat = CASES[ci][3];
    rdy = CASES[ci][4]; vld = CASES[ci][5]; chg = CASES[ci][6];
    npix = w * h;
    tag = (chg != 0) ? "R7" : ((ks == 1) ? "R8" : ((ks >= 3) ? "R3" : "R2"));
    build_expect(w, h, ks, pat);
    load_kernel(ks);
    @(negedge clk);
    sof_i = 1'b1; width_i = DIM_W'(w); height_i = DIM_W'(h);
    @(negedge clk);
    sof_i = 1'b0;
    if (chg != 0) begin width_i = DIM_W'(w + 2); height_i = DIM_W'(h + 1); end
    pidx = 0; oidx = 0; cyc = 0; done = 0; held = 0; drain_bad = 0;
    first_out = -1; last_out = -1; held_data = '0;
    while (!done && cyc < 20000) begin
      out_ready_i = mode_on(rdy, cyc);
      in_valid_i  = (pidx < npix) && mode_on(vld, cyc);
      in_data_i   = (pidx < npix) ? PIX_W'(img[pidx]) : '0;
      #1;
      if (held) begin
        check(out_valid_o && out_data_o == held_data, "R5 hold", int'($signed(out_data_o)), int'($signed(held_data)));
        held = 0;
      end
      if (out_valid_o && !out_ready_i) begin held = 1; held_data = out_data_o; end
      if (pidx == npix && in_ready_o) drain_bad = 1;
      if (in_valid_i && in_ready_o) pidx++;
      if (out_valid_o && out_ready_i) begin
        if (first_out < 0) first_out = cyc;
        last_out = cyc;
        check(int'($signed(out_data_o)) == expv[oidx], tag, int'($signed(out_data_o)), expv[oidx]);
        check(out_last_o == (oidx == npix - 1), "R1 last flag", int'(out_last_o), int'(oidx == npix - 1));
        oidx++;
        if (out_last_o) done = 1;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid_i = 1'b0; out_ready_i = 1'b1;
    check(done, "R1 frame completes", int'(done), 1);
    check(oidx == npix, "R1 result count", oidx, npix);
    check(!drain_bad, "R6 no input after W*H", int'(drain_bad), 0);
    if (rdy == 0 && vld == 0) begin
      check(first_out == w + 2, "R4 first result edge", first_out, w + 2);
      check(last_out == w * (h + 1) + 1, "R4 last result edge", last_out, w * (h + 1) + 1);
    end
    #1;
    check(!in_ready_o && !out_valid_o, "R10 idle after frame", int'(in_ready_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready_o && !out_valid_o && !out_last_o, "R9 reset state", int'(in_ready_o | out_valid_o | out_last_o), 0);
    rst_ni = 1'b1;
    // R10: inputs offered before any start pulse are refused
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_data_i = PIX_W'(k * 7);
      #1;
      check(!in_ready_o && !out_valid_o, "R10 idle ignores input", int'(in_ready_o | out_valid_o), 0);
    end
    in_valid_i = 1'b0;

    for (int ci = 0; ci < NCASE; ci++) run_frame(ci);

    // R9: reset in the middle of a frame
    load_kernel(0);
    @(negedge clk);
    sof_i = 1'b1; width_i = 5; height_i = 4;
    @(negedge clk);
    sof_i = 1'b0;
    for (int k = 0; k < 9; k++) begin
      in_valid_i = 1'b1; in_data_i = PIX_W'(k);
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(!in_ready_o && !out_valid_o && !out_last_o, "R9 mid-frame reset", int'(in_ready_o | out_valid_o | out_last_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    check(!in_ready_o, "R9 idle until start", int'(in_ready_o), 0);
    run_frame(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule